// File: doc/BRIEF.md
# DMA Snoop Tag Controller

This block manages the tag and state storage of a small direct-mapped write-back cache that shares a memory bus with a DMA engine. Each cache line holds one data word together with a valid bit, a dirty bit and an address tag. The storage has two lookup ports. One port serves the processor. The other port watches DMA cycles on the bus, so both lookups can happen in the same clock cycle.

For each DMA cycle it observes, the block chooses one of three actions. If the cycle is a read of a dirty line, the cache supplies the data itself and tells memory to stay silent. If the cycle is a write that hits a line, the cache drops its copy. In every other case the cache does nothing. The processor port is a valid/ready request channel followed by one response per accepted request. A request is held, with all its fields unchanged, until `req_ready` is high. The response has no back-pressure. The snoop input and the intervention outputs are plain signals that are evaluated in the same cycle.

Addresses are `{tag, index}`. The index is the low `IDX_W` bits of the address and the tag is the bits above them.

Top module: `snoop_tag_ctrl`

## Requirements
- R1: After reset every line is invalid. A processor read then gets `resp_hit`=0 and `resp_data`=0, and a DMA read does not raise `mem_inhibit`.
- R2: Processor requests use `req_op` 0=read, 1=write, 2=fill (3 acts as a read). A write installs the line as valid and dirty with `req_wdata`. A fill installs it as valid and clean. Every accepted request gives exactly one `resp_valid` pulse in the cycle after acceptance. In that response, `resp_hit` tells whether the line was valid with a matching tag at acceptance, and `resp_data` is the stored word on a hit and 0 otherwise.
- R3: A DMA read to an address that is not cached leaves `mem_inhibit` low and `ivn_data` at 0.
- R4: A DMA read that hits a clean line leaves `mem_inhibit` low, and the line stays valid.
- R5: A DMA read that hits a dirty line raises `mem_inhibit` in the same cycle, with `ivn_data` equal to the line's word. The line stays valid and dirty, so a later DMA read intervenes again. When no intervention takes place, `ivn_data` is 0.
- R6: A DMA write that hits a clean line invalidates that line.
- R7: A DMA write that hits a dirty line invalidates that line and discards its data, with `mem_inhibit` low.
- R8: A DMA write whose tag differs from the tag stored at its index leaves that line unchanged.
- R9: When a DMA write hits the line at the index that a processor request targets in the same cycle, `req_ready` is low and the invalidation takes effect. The processor request is accepted once the conflict is gone.
- R10: A DMA cycle to a different index does not lower `req_ready`, and both accesses complete in the same cycle.
- R11: No response is produced for a request that is presented while `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 2 | 0 read, 1 write, 2 fill |
| req_addr | input | TAG_W+IDX_W | Processor address {tag,index} |
| req_wdata | input | DATA_W | Word for write or fill |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Line matched at acceptance |
| resp_data | output | DATA_W | Stored word on hit, else 0 |
| snp_valid | input | 1 | DMA bus cycle present |
| snp_write | input | 1 | 1 for a DMA write, 0 for a DMA read |
| snp_addr | input | TAG_W+IDX_W | DMA address {tag,index} |
| mem_inhibit | output | 1 | Memory must not respond; the cache supplies data |
| ivn_data | output | DATA_W | Intervention word, 0 when not intervening |

## Verification
The hardest case to reach is the collision between a DMA write that hits a line and a processor request to the same index in the same cycle. Reaching it takes three steps. The stimulus first installs a line with a fill. It then presents a processor write and a DMA write to that address on the same falling edge. Finally it holds the request through the stall, which also shows that no response leaks out while ready is low. A second pairing sends a DMA write and a processor read to two different indices at once, which shows that the two ports really work in parallel.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FILL  = 2'd2,
    OP_RSVD  = 2'd3
  } proc_op_e;

  typedef enum logic [1:0] {
    ACT_NONE      = 2'd0,
    ACT_INTERVENE = 2'd1,
    ACT_PURGE     = 2'd2
  } snoop_act_e;
endpackage

// File: rtl/snp_tag_array.sv
module snp_tag_array #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor lookup port
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  // snoop lookup port
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic              b_dirty,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  // processor install
  input  logic              w_en,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data,
  input  logic              w_dirty,
  // snoop invalidate, wins over install
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  drt_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else begin
      if (w_en) begin
        vld_q[w_idx] <= 1'b1;
        drt_q[w_idx] <= w_dirty;
      end
      if (inv_en) begin
        vld_q[inv_idx] <= 1'b0;
        drt_q[inv_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (w_en) begin
      tag_q[w_idx]  <= w_tag;
      data_q[w_idx] <= w_data;
    end
  end

  assign a_valid = vld_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_valid = vld_q[b_idx];
  assign b_dirty = drt_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_data  = data_q[b_idx];

  // R6
  inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld_q[$past(inv_idx)]);

  // R2
  install_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_en && !(inv_en && inv_idx == w_idx)) |=> vld_q[$past(w_idx)]);
endmodule

// File: rtl/snp_classify.sv
module snp_classify
  import snp_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic              line_valid,
  input  logic              line_dirty,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output snoop_act_e        act,
  output logic              inhibit,
  output logic [DATA_W-1:0] ivn_data
);
  logic hit;

  assign hit = snp_valid && line_valid && (line_tag == snp_tag);

  always_comb begin
    act = ACT_NONE;
    if (hit) begin
      if (snp_write)       act = ACT_PURGE;
      else if (line_dirty) act = ACT_INTERVENE;
    end
  end

  assign inhibit  = (act == ACT_INTERVENE);
  assign ivn_data = inhibit ? line_data : '0;
endmodule

// File: rtl/snp_proc_port.sv
module snp_proc_port
  import snp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_op,
  input  logic [TAG_W+IDX_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic                    stall,
  input  logic                    line_valid,
  input  logic [TAG_W-1:0]        line_tag,
  input  logic [DATA_W-1:0]       line_data,
  output logic                    req_ready,
  output logic [IDX_W-1:0]        lk_idx,
  output logic                    w_en,
  output logic [TAG_W-1:0]        w_tag,
  output logic [DATA_W-1:0]       w_data,
  output logic                    w_dirty,
  output logic                    resp_valid,
  output logic                    resp_hit,
  output logic [DATA_W-1:0]       resp_data
);
  localparam int ADDR_W = TAG_W + IDX_W;

  proc_op_e op;
  logic     accept;
  logic     hit;

  assign op        = proc_op_e'(req_op);
  assign lk_idx    = req_addr[IDX_W-1:0];
  assign w_tag     = req_addr[ADDR_W-1:IDX_W];
  assign w_data    = req_wdata;
  assign req_ready = !stall;
  assign accept    = req_valid && req_ready;
  assign hit       = line_valid && (line_tag == w_tag);
  assign w_en      = accept && (op == OP_WRITE || op == OP_FILL);
  assign w_dirty   = (op == OP_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= accept;
      resp_hit   <= accept && hit;
      resp_data  <= (accept && hit) ? line_data : '0;
    end
  end

  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R11
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid && req_ready));
endmodule

// File: rtl/snoop_tag_ctrl.sv
module snoop_tag_ctrl
  import snp_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [TAG_W+IDX_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    resp_valid,
  output logic                    resp_hit,
  output logic [DATA_W-1:0]       resp_data,
  input  logic                    snp_valid,
  input  logic                    snp_write,
  input  logic [TAG_W+IDX_W-1:0]  snp_addr,
  output logic                    mem_inhibit,
  output logic [DATA_W-1:0]       ivn_data
);
  localparam int ADDR_W = TAG_W + IDX_W;

  logic [IDX_W-1:0]  p_idx, s_idx;
  logic [TAG_W-1:0]  s_tag;
  logic              a_valid, b_valid, b_dirty;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic              w_en, w_dirty, stall, purge;
  logic [TAG_W-1:0]  w_tag;
  logic [DATA_W-1:0] w_data;
  snoop_act_e        act;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign purge = (act == ACT_PURGE);
  assign stall = purge && (s_idx == req_addr[IDX_W-1:0]);

  snp_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .a_idx(p_idx), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
    .b_idx(s_idx), .b_valid(b_valid), .b_dirty(b_dirty), .b_tag(b_tag), .b_data(b_data),
    .w_en(w_en), .w_idx(p_idx), .w_tag(w_tag), .w_data(w_data), .w_dirty(w_dirty),
    .inv_en(purge), .inv_idx(s_idx)
  );

  snp_classify #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_classify (
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_tag(s_tag),
    .line_valid(b_valid), .line_dirty(b_dirty), .line_tag(b_tag), .line_data(b_data),
    .act(act), .inhibit(mem_inhibit), .ivn_data(ivn_data)
  );

  snp_proc_port #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .stall(stall), .line_valid(a_valid), .line_tag(a_tag), .line_data(a_data),
    .req_ready(req_ready), .lk_idx(p_idx), .w_en(w_en), .w_tag(w_tag),
    .w_data(w_data), .w_dirty(w_dirty),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data)
  );

  // R5
  inhibit_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_inhibit |-> (snp_valid && !snp_write));

  // R7
  purge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge |-> !mem_inhibit);

  // R9
  conflict_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (purge && req_valid && s_idx == req_addr[IDX_W-1:0]) |-> !req_ready);

  // R10
  other_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && s_idx != req_addr[IDX_W-1:0]) |-> req_ready);
endmodule

// File: tb/tb_snoop_tag_ctrl.sv
module tb_snoop_tag_ctrl;
  localparam int IDX_W  = 4;
  localparam int TAG_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = TAG_W + IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_op = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              resp_valid, resp_hit;
  logic [DATA_W-1:0] resp_data;
  logic              snp_valid = 1'b0;
  logic              snp_write = 1'b0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              mem_inhibit;
  logic [DATA_W-1:0] ivn_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic              hit;
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  snoop_tag_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .mem_inhibit(mem_inhibit), .ivn_data(ivn_data)
  );

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected responses as the design produces them
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb_q.size() == 0) begin
        check("R11", "response with nothing outstanding", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, "resp_hit", resp_hit, e.hit);
        check(e.req, "resp_data", resp_data, e.data);
      end
    end
  end

  task automatic proc_req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic eh,
                          input logic [DATA_W-1:0] ed, input string req);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    e.hit = eh; e.data = ed; e.req = req;
    sb_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic snoop(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic ei, input logic [DATA_W-1:0] ed, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_write = wr; snp_addr = a;
    #1;
    check(req, "mem_inhibit", mem_inhibit, ei);
    check(req, "ivn_data", ivn_data, ed);
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "resp_valid after reset", resp_valid, 0);
    check("R1", "req_ready after reset", req_ready, 1);
    proc_req(2'd0, 12'h015, 0, 1'b0, 0, "R1");
    snoop(1'b0, 12'h015, 1'b0, 0, "R1");

    // R2 fill, write, read
    proc_req(2'd2, 12'h015, 32'hA1A1_0001, 1'b0, 0, "R2");
    proc_req(2'd0, 12'h015, 0, 1'b1, 32'hA1A1_0001, "R2");
    proc_req(2'd1, 12'h023, 32'hB2B2_0002, 1'b0, 0, "R2");
    proc_req(2'd3, 12'h023, 0, 1'b1, 32'hB2B2_0002, "R2");

    // R4 clean read hit: memory answers, line stays
    snoop(1'b0, 12'h015, 1'b0, 0, "R4");
    proc_req(2'd0, 12'h015, 0, 1'b1, 32'hA1A1_0001, "R4");

    // R3 read misses: wrong tag, never-filled index
    snoop(1'b0, 12'h0F5, 1'b0, 0, "R3");
    snoop(1'b0, 12'h037, 1'b0, 0, "R3");

    // R5 dirty read hit intervenes, twice
    snoop(1'b0, 12'h023, 1'b1, 32'hB2B2_0002, "R5");
    snoop(1'b0, 12'h023, 1'b1, 32'hB2B2_0002, "R5");

    // R8 write with other tag leaves line
    snoop(1'b1, 12'h0F3, 1'b0, 0, "R8");
    snoop(1'b0, 12'h023, 1'b1, 32'hB2B2_0002, "R8");

    // R6 write hits clean line
    snoop(1'b1, 12'h015, 1'b0, 0, "R6");
    proc_req(2'd0, 12'h015, 0, 1'b0, 0, "R6");

    // R7 write hits dirty line
    snoop(1'b1, 12'h023, 1'b0, 0, "R7");
    snoop(1'b0, 12'h023, 1'b0, 0, "R7");
    proc_req(2'd0, 12'h023, 0, 1'b0, 0, "R7");

    // R9 / R11 same-index collision
    proc_req(2'd2, 12'h046, 32'hC3C3_0003, 1'b0, 0, "R9");
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = 12'h046; req_wdata = 32'hD4D4_0004;
    snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 12'h046;
    #1;
    check("R9", "req_ready during collision", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    check("R11", "resp_valid after stalled cycle", resp_valid, 0);
    snp_valid = 1'b0;
    #1;
    check("R9", "req_ready after collision", req_ready, 1);
    begin
      exp_t e;
      e.hit = 1'b0; e.data = 0; e.req = "R9";
      sb_q.push_back(e);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    proc_req(2'd0, 12'h046, 0, 1'b1, 32'hD4D4_0004, "R9");

    // R10 two indices in one cycle
    proc_req(2'd2, 12'h058, 32'hE5E5_0005, 1'b0, 0, "R10");
    proc_req(2'd2, 12'h069, 32'hF6F6_0006, 1'b0, 0, "R10");
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_addr = 12'h058;
    snp_valid = 1'b1; snp_write = 1'b1; snp_addr = 12'h069;
    #1;
    check("R10", "req_ready with other-index snoop", req_ready, 1);
    begin
      exp_t e;
      e.hit = 1'b1; e.data = 32'hE5E5_0005; e.req = "R10";
      sb_q.push_back(e);
    end
    @(posedge clk); #1;
    req_valid = 1'b0; snp_valid = 1'b0;
    proc_req(2'd0, 12'h069, 0, 1'b0, 0, "R10");

    repeat (3) @(negedge clk);
    check("R2", "outstanding responses", sb_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule